// File: doc/BRIEF.md
# DRAM Row-Strobe Ownership Arbiter

This block decides, cycle by cycle, which of three events owns the DRAM row strobes. The three events are a refresh, an access from the processor on Port A, and an access from Port B. Port A has a front end whose behaviour is picked by a mode pin. In latched mode, a request seen together with chip select is recorded and granted on a later clock edge. In strobe mode, the same request opens the row within the same cycle when the arbiter is idle and nothing else is asking. Port A then keeps the row open for as long as its hold line stays high. Port B has a single level request. It opens the row at once when it is the only event, and it raises an early acknowledge that tracks its row strobe.

There is one row strobe per bank. The bank is taken from the top bits of the request address. A refresh drives every strobe together, and the row it refreshes comes from an internal counter. Each strobe stays active for at least a set number of clocks, and each is followed by a precharge gap of at least a set number of clocks. A refresh request that is held produces back-to-back refreshes. Ties go to refresh first; between the two ports the winner alternates.

Top module: `dram_arb_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, all row strobes, `rfsh_busy`, `b_early_ack` and `mem_addr` are zero, given idle inputs.
- R2: A refresh raises `rfsh_busy` one cycle before all strobes assert together. The strobes stay high for exactly RAS_MIN cycles. `rfsh_busy` stays high through the PRE_CYC precharge cycles that follow and then falls, so it is never low while a refresh strobe is active.
- R3: While `rfsh_req` stays high, refreshes repeat, and each starts one idle cycle after the previous precharge ends. The refresh row counter advances by one per refresh and is shown as the row field of `mem_addr` (all other fields zero) while a refresh strobe is active.
- R4: In latched mode (`mode_strobe`=0), the strobe of bank `addr_in[AW-1 -: BANK_W]` rises in the cycle after the clock edge that samples a new `a_strobe & a_sel` (a rising edge of that product), when the arbiter is idle.
- R5: In strobe mode (`mode_strobe`=1), a new `a_strobe & a_sel` while the arbiter is idle, with no refresh request and no Port B request, raises the bank's strobe in the same cycle.
- R6: A Port A access lasts at least RAS_MIN strobe cycles. Its strobe falls in the cycle after the first edge at which `a_hold` is sampled low once that minimum has been reached.
- R7: A new `b_req` that is the only event while idle raises the bank strobe and `b_early_ack` in the same cycle. `b_early_ack` is high exactly when a Port B strobe is active. The access ends like R6, with `b_req` in place of `a_hold`.
- R8: A request that arrives while another owner is active or precharging is held pending and is granted in the idle cycle after the precharge. Its strobe rises one cycle later.
- R9: With several events pending in the idle cycle, refresh wins. Between Port A and Port B, the port not served last wins; after reset Port A wins the first tie.
- R10: With `latch_on`=1, the address is captured at the edge that samples a new request, and `mem_addr` shows the captured value during that port's access. With `latch_on`=0, `mem_addr` follows `addr_in`. In a same-cycle start, `mem_addr` equals `addr_in`. Outside Port A and Port B accesses, `mem_addr` is zero except as stated in R3. Apart from refresh, at most one strobe is active.
- R11: Between the fall of any strobe and the next rise, at least PRE_CYC cycles pass with all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_strobe | input | 1 | Port A mode: 0 latched start, 1 same-cycle start |
| latch_on | input | 1 | 1 captures the address on a new request, 0 passes it through |
| rfsh_req | input | 1 | Refresh request, held for a burst |
| a_strobe | input | 1 | Port A request strobe |
| a_sel | input | 1 | Port A chip select |
| a_hold | input | 1 | Port A access hold; low ends the access |
| b_req | input | 1 | Port B request, held for the access |
| addr_in | input | BANK_W+ROW_W+COL_W | Request address {bank, row, column} |
| row_strobe | output | 2**BANK_W | Active-high row strobe, one per bank |
| rfsh_busy | output | 1 | Refresh in progress |
| b_early_ack | output | 1 | Port B early acknowledge |
| mem_addr | output | BANK_W+ROW_W+COL_W | Address of the current owner |

## Verification
The assertions assume that the inputs change away from the clock edge and that they stay idle during reset. They also assume that `a_hold` is raised together with or before the end of the Port A strobe, and that RAS_MIN is at least 2 and PRE_CYC at least 1. The bench drives every input one nanosecond after a rising edge. It keeps the inputs low through reset and always raises `a_hold` together with the strobe. It also uses the default timing parameters, so the width, gap and busy-ordering properties see only legal request patterns.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ARM  = 2'd1,
        PH_ACT  = 2'd2,
        PH_PRE  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_RFSH = 2'd1,
        OWN_A    = 2'd2,
        OWN_B    = 2'd3
    } owner_e;

    typedef struct packed {
        phase_e ph;
        owner_e own;
    } own_state_t;

    localparam own_state_t ST_RESET = '{ph: PH_IDLE, own: OWN_NONE};

    function automatic int max2(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/dram_arb_port.sv
module dram_arb_port #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          take,
    input  logic          latch_on,
    input  logic [AW-1:0] addr_in,
    output logic          fresh,
    output logic          pend,
    output logic [AW-1:0] lat_addr,
    output logic [AW-1:0] eff_addr
);
    logic req_q;

    // a request counts once, on the cycle its level first appears
    assign fresh    = req & ~req_q;
    assign eff_addr = (fresh || !latch_on) ? addr_in : lat_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= 1'b0;
            pend     <= 1'b0;
            lat_addr <= '0;
        end else begin
            req_q    <= req;
            lat_addr <= eff_addr;
            if (take)
                pend <= 1'b0;
            else if (fresh)
                pend <= 1'b1;
        end
    end
endmodule

// File: rtl/dram_arb_fsm.sv
module dram_arb_fsm
    import dram_arb_pkg::*;
#(
    parameter int RAS_MIN = 3,
    parameter int PRE_CYC = 2,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rfsh_req,
    input  logic              a_cand,
    input  logic              b_cand,
    input  logic              a_imm_ok,
    input  logic              b_imm_ok,
    input  logic              a_rel,
    input  logic              b_rel,
    input  logic [BANK_W-1:0] a_bank,
    input  logic [BANK_W-1:0] b_bank,
    output own_state_t        st,
    output logic [BANK_W-1:0] bank_q,
    output logic              take_a,
    output logic              take_b,
    output logic              imm_a,
    output logic              imm_b,
    output logic [ROW_W-1:0]  rcnt
);
    localparam int CNT_MAX = max2(RAS_MIN, PRE_CYC);
    localparam int CW      = $clog2(CNT_MAX + 2);

    logic [CW-1:0] cnt, cnt_inc;
    logic          last_b;
    logic          idle, win_a, win_b, rel;

    assign idle    = (st.ph == PH_IDLE);
    // refresh first; between ports the one not served last
    assign win_a   = idle && !rfsh_req && a_cand && (!b_cand || last_b);
    assign win_b   = idle && !rfsh_req && b_cand && !win_a;
    assign imm_a   = win_a && a_imm_ok && !b_cand;
    assign imm_b   = win_b && b_imm_ok && !a_cand;
    assign take_a  = win_a;
    assign take_b  = win_b;
    assign cnt_inc = cnt + CW'(1);

    always_comb begin
        case (st.own)
            OWN_A:   rel = a_rel;
            OWN_B:   rel = b_rel;
            default: rel = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_RESET;
            cnt    <= '0;
            bank_q <= '0;
            last_b <= 1'b1;
            rcnt   <= '0;
        end else begin
            case (st.ph)
                PH_IDLE: begin
                    if (rfsh_req) begin
                        st <= '{ph: PH_ARM, own: OWN_RFSH};
                    end else if (win_a) begin
                        st     <= '{ph: PH_ACT, own: OWN_A};
                        cnt    <= imm_a ? CW'(1) : '0;
                        bank_q <= a_bank;
                        last_b <= 1'b0;
                    end else if (win_b) begin
                        st     <= '{ph: PH_ACT, own: OWN_B};
                        cnt    <= imm_b ? CW'(1) : '0;
                        bank_q <= b_bank;
                        last_b <= 1'b1;
                    end
                end
                PH_ARM: begin
                    st.ph <= PH_ACT;
                    cnt   <= '0;
                end
                PH_ACT: begin
                    if (cnt_inc >= CW'(RAS_MIN) && rel) begin
                        st.ph <= PH_PRE;
                        cnt   <= '0;
                        if (st.own == OWN_RFSH)
                            rcnt <= rcnt + ROW_W'(1);
                    end else if (cnt_inc <= CW'(RAS_MIN)) begin
                        cnt <= cnt_inc;
                    end
                end
                default: begin
                    if (cnt_inc >= CW'(PRE_CYC)) begin
                        st  <= ST_RESET;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dram_arb_top.sv
module dram_arb_top
    import dram_arb_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 4,
    parameter int COL_W   = 4,
    parameter int RAS_MIN = 3,
    parameter int PRE_CYC = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            mode_strobe,
    input  logic                            latch_on,
    input  logic                            rfsh_req,
    input  logic                            a_strobe,
    input  logic                            a_sel,
    input  logic                            a_hold,
    input  logic                            b_req,
    input  logic [BANK_W+ROW_W+COL_W-1:0]   addr_in,
    output logic [(2**BANK_W)-1:0]          row_strobe,
    output logic                            rfsh_busy,
    output logic                            b_early_ack,
    output logic [BANK_W+ROW_W+COL_W-1:0]   mem_addr
);
    localparam int AW    = BANK_W + ROW_W + COL_W;
    localparam int NBANK = 2 ** BANK_W;

    logic          a_fresh, a_pend, b_fresh, b_pend;
    logic [AW-1:0] a_lat, a_eff, b_lat, b_eff;
    logic          take_a, take_b, imm_a, imm_b, active;
    own_state_t    st;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  rcnt;

    dram_arb_port #(.AW(AW)) u_port_a (
        .clk(clk), .rst(rst), .req(a_strobe & a_sel), .take(take_a),
        .latch_on(latch_on), .addr_in(addr_in), .fresh(a_fresh),
        .pend(a_pend), .lat_addr(a_lat), .eff_addr(a_eff)
    );

    dram_arb_port #(.AW(AW)) u_port_b (
        .clk(clk), .rst(rst), .req(b_req), .take(take_b),
        .latch_on(latch_on), .addr_in(addr_in), .fresh(b_fresh),
        .pend(b_pend), .lat_addr(b_lat), .eff_addr(b_eff)
    );

    dram_arb_fsm #(
        .RAS_MIN(RAS_MIN), .PRE_CYC(PRE_CYC), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .rfsh_req(rfsh_req),
        .a_cand(a_pend | a_fresh), .b_cand(b_pend | b_fresh),
        .a_imm_ok(mode_strobe & a_fresh & ~a_pend),
        .b_imm_ok(b_fresh & ~b_pend),
        .a_rel(~a_hold), .b_rel(~b_req),
        .a_bank(a_eff[AW-1 -: BANK_W]), .b_bank(b_eff[AW-1 -: BANK_W]),
        .st(st), .bank_q(bank_q), .take_a(take_a), .take_b(take_b),
        .imm_a(imm_a), .imm_b(imm_b), .rcnt(rcnt)
    );

    assign active = (st.ph == PH_ACT);

    always_comb begin
        if (imm_a || imm_b)
            row_strobe = NBANK'(1) << addr_in[AW-1 -: BANK_W];
        else if (active && st.own == OWN_RFSH)
            row_strobe = '1;
        else if (active)
            row_strobe = NBANK'(1) << bank_q;
        else
            row_strobe = '0;
    end

    always_comb begin
        mem_addr = '0;
        if (imm_a || imm_b) begin
            mem_addr = addr_in;
        end else if (active) begin
            case (st.own)
                OWN_RFSH: mem_addr = {{BANK_W{1'b0}}, rcnt, {COL_W{1'b0}}};
                OWN_A:    mem_addr = latch_on ? a_lat : addr_in;
                OWN_B:    mem_addr = latch_on ? b_lat : addr_in;
                default:  mem_addr = '0;
            endcase
        end
    end

    assign rfsh_busy   = (st.own == OWN_RFSH);
    assign b_early_ack = imm_b || (active && st.own == OWN_B);
endmodule

// File: rtl/dram_arb_chk.sv
module dram_arb_chk #(
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 4,
    parameter int COL_W   = 4,
    parameter int RAS_MIN = 3,
    parameter int PRE_CYC = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic [(2**BANK_W)-1:0]        row_strobe,
    input logic                          rfsh_busy,
    input logic                          b_early_ack
);
    logic        any_rs, prev_any;
    logic [15:0] hi_cnt, lo_cnt;

    assign any_rs = |row_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_any <= 1'b0;
            hi_cnt   <= '0;
            lo_cnt   <= 16'(PRE_CYC);
        end else begin
            prev_any <= any_rs;
            if (any_rs) begin
                lo_cnt <= '0;
                if (hi_cnt < 16'(RAS_MIN)) hi_cnt <= hi_cnt + 16'd1;
            end else begin
                hi_cnt <= '0;
                if (lo_cnt < 16'(PRE_CYC)) lo_cnt <= lo_cnt + 16'd1;
            end
        end
    end

    p_busy_lead_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rfsh_busy) |-> !any_rs);
    p_busy_tail_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rfsh_busy) |-> !any_rs && !prev_any);
    p_all_is_rfsh_r2: assert property (@(posedge clk) disable iff (rst)
        (&row_strobe) |-> rfsh_busy);
    p_min_width_r6: assert property (@(posedge clk) disable iff (rst)
        (prev_any && !any_rs) |-> (hi_cnt >= 16'(RAS_MIN)));
    p_ack_r7: assert property (@(posedge clk) disable iff (rst)
        b_early_ack |-> (any_rs && !rfsh_busy));
    p_one_bank_r10: assert property (@(posedge clk) disable iff (rst)
        !rfsh_busy |-> $onehot0(row_strobe));
    p_gap_r11: assert property (@(posedge clk) disable iff (rst)
        (!prev_any && any_rs) |-> (lo_cnt >= 16'(PRE_CYC)));
endmodule

bind dram_arb_top dram_arb_chk #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .RAS_MIN(RAS_MIN), .PRE_CYC(PRE_CYC)
) u_chk (
    .clk(clk), .rst(rst), .row_strobe(row_strobe),
    .rfsh_busy(rfsh_busy), .b_early_ack(b_early_ack)
);

// File: tb/tb_dram_arb_top.sv
`timescale 1ns/1ps
module tb_dram_arb_top;
    localparam int BW = 2, RW = 4, CLW = 4, RMIN = 3, PCYC = 2;
    localparam int AW = BW + RW + CLW;
    localparam int NB = 2 ** BW;

    logic clk = 1'b0, rst = 1'b1;
    logic mode_strobe = 1'b0, latch_on = 1'b1, rfsh_req = 1'b0;
    logic a_strobe = 1'b0, a_sel = 1'b0, a_hold = 1'b0, b_req = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [NB-1:0] row_strobe;
    logic rfsh_busy, b_early_ack;
    logic [AW-1:0] mem_addr;

    dram_arb_top #(.BANK_W(BW), .ROW_W(RW), .COL_W(CLW),
                   .RAS_MIN(RMIN), .PRE_CYC(PCYC)) dut (
        .clk(clk), .rst(rst), .mode_strobe(mode_strobe), .latch_on(latch_on),
        .rfsh_req(rfsh_req), .a_strobe(a_strobe), .a_sel(a_sel), .a_hold(a_hold),
        .b_req(b_req), .addr_in(addr_in), .row_strobe(row_strobe),
        .rfsh_busy(rfsh_busy), .b_early_ack(b_early_ack), .mem_addr(mem_addr)
    );

    always #4 clk = ~clk;

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit started = 0, done = 0;
    string tag = "R1";

    // reference model state (phase: 0 idle 1 arm 2 on 3 precharge; who: 0 none 1 refresh 2 A 3 B)
    int ph, who, cnt, lastb, apend, bpend, aprev, bprev, rrow, bnk;
    logic [AW-1:0] alat, blat;
    int n_ph, n_who, n_cnt, n_lastb, n_apend, n_bpend, n_aprev, n_bprev, n_rrow, n_bnk;
    logic [AW-1:0] n_alat, n_blat;
    int burst_starts = 0;
    logic [NB-1:0] last_rs = '0;

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    function automatic int bank_of(input logic [AW-1:0] a);
        return int'(a[AW-1 -: BW]);
    endfunction

    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (rst) begin
            ph = 0; who = 0; cnt = 0; lastb = 1; apend = 0; bpend = 0;
            aprev = 0; bprev = 0; rrow = 0; bnk = 0; alat = '0; blat = '0;
        end else begin
            ph = n_ph; who = n_who; cnt = n_cnt; lastb = n_lastb;
            apend = n_apend; bpend = n_bpend; aprev = n_aprev; bprev = n_bprev;
            rrow = n_rrow; bnk = n_bnk; alat = n_alat; blat = n_blat;
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected below 20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        #2;
        if (started && !done) begin
            int anew, bnew, acand, bcand, winA, winB, immA, immB, rel, c1;
            int e_rs, e_busy, e_ack, e_addr;
            anew  = (a_strobe && a_sel && !aprev) ? 1 : 0;
            bnew  = (b_req && !bprev) ? 1 : 0;
            acand = apend | anew;
            bcand = bpend | bnew;
            winA = 0; winB = 0;
            if (ph == 0 && !rfsh_req) begin
                if (acand && (!bcand || lastb)) winA = 1;
                else if (bcand) winB = 1;
            end
            immA = (winA && mode_strobe && anew && !apend && !bcand) ? 1 : 0;
            immB = (winB && bnew && !bpend && !acand) ? 1 : 0;

            e_rs = 0; e_addr = 0;
            if (immA || immB) begin
                e_rs = 1 << bank_of(addr_in);
                e_addr = int'(addr_in);
            end else if (ph == 2) begin
                if (who == 1) begin
                    e_rs = (1 << NB) - 1;
                    e_addr = rrow << CLW;
                end else begin
                    e_rs = 1 << bnk;
                    if (who == 2) e_addr = latch_on ? int'(alat) : int'(addr_in);
                    else          e_addr = latch_on ? int'(blat) : int'(addr_in);
                end
            end
            e_busy = (who == 1) ? 1 : 0;
            e_ack  = (immB || (ph == 2 && who == 3)) ? 1 : 0;

            chk("row_strobe", int'(row_strobe), e_rs);
            chk("rfsh_busy", int'(rfsh_busy), e_busy);
            chk("b_early_ack", int'(b_early_ack), e_ack);
            chk("mem_addr", int'(mem_addr), e_addr);
            if (row_strobe == '1 && last_rs != '1) burst_starts++;
            last_rs = row_strobe;

            // next model state, applied at the coming edge
            n_ph = ph; n_who = who; n_cnt = cnt; n_lastb = lastb; n_rrow = rrow; n_bnk = bnk;
            n_aprev = (a_strobe && a_sel) ? 1 : 0;
            n_bprev = b_req ? 1 : 0;
            n_alat = (!latch_on || anew) ? addr_in : alat;
            n_blat = (!latch_on || bnew) ? addr_in : blat;
            n_apend = winA ? 0 : (anew ? 1 : apend);
            n_bpend = winB ? 0 : (bnew ? 1 : bpend);
            if (ph == 0) begin
                if (rfsh_req) begin n_ph = 1; n_who = 1; end
                else if (winA) begin
                    n_ph = 2; n_who = 2; n_cnt = immA; n_lastb = 0;
                    n_bnk = bank_of((anew || !latch_on) ? addr_in : alat);
                end else if (winB) begin
                    n_ph = 2; n_who = 3; n_cnt = immB; n_lastb = 1;
                    n_bnk = bank_of((bnew || !latch_on) ? addr_in : blat);
                end
            end else if (ph == 1) begin
                n_ph = 2; n_cnt = 0;
            end else if (ph == 2) begin
                c1 = cnt + 1;
                rel = (who == 1) ? 1 : (who == 2) ? !a_hold : !b_req;
                if (c1 >= RMIN && rel) begin
                    n_ph = 3; n_cnt = 0;
                    if (who == 1) n_rrow = (rrow + 1) % (1 << RW);
                end else n_cnt = (c1 < RMIN) ? c1 : RMIN;
            end else begin
                c1 = cnt + 1;
                if (c1 >= PCYC) begin n_ph = 0; n_who = 0; n_cnt = 0; end
                else n_cnt = c1;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] mk(input int b, input int r, input int c);
        return {BW'(b), RW'(r), CLW'(c)};
    endfunction

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(3);

        // R5 R6 R10: strobe mode, same-cycle start, captured address held
        tag = "R5"; mode_strobe = 1; latch_on = 1; addr_in = mk(2, 5, 7);
        a_strobe = 1; a_sel = 1; a_hold = 1;
        cyc(1);
        tag = "R10"; addr_in = mk(1, 9, 3);
        cyc(4);
        tag = "R6"; a_hold = 0; a_strobe = 0;
        cyc(8);

        // R4: latched mode, start on the following edge
        tag = "R4"; mode_strobe = 0; addr_in = mk(3, 2, 1);
        a_strobe = 1; a_sel = 1; a_hold = 1;
        cyc(1);
        a_strobe = 0;
        cyc(4);
        a_hold = 0;
        cyc(8);

        // R7: port B alone, early acknowledge
        tag = "R7"; addr_in = mk(1, 4, 4); b_req = 1;
        cyc(5);
        b_req = 0;
        cyc(8);

        // R2: single refresh
        tag = "R2"; rfsh_req = 1;
        cyc(1);
        rfsh_req = 0;
        cyc(10);

        // R3: burst of refreshes while held
        tag = "R3"; burst_starts = 0; rfsh_req = 1;
        cyc(22);
        rfsh_req = 0;
        cyc(10);
        n_checks++;
        if (burst_starts < 3) begin
            n_fail++;
            $display("FAIL R3 burst count: got %0d expected at least 3", burst_starts);
        end

        // R9: after an A access, a tie between A and B goes to B
        tag = "R9"; mode_strobe = 1; addr_in = mk(0, 1, 1);
        a_strobe = 1; a_sel = 1; a_hold = 1;
        cyc(4);
        a_hold = 0; a_strobe = 0;
        cyc(8);
        addr_in = mk(2, 6, 6);
        a_strobe = 1; a_sel = 1; a_hold = 1; b_req = 1;
        cyc(5);
        b_req = 0;
        cyc(10);
        a_hold = 0; a_strobe = 0;
        cyc(8);

        // R9: refresh beats a simultaneous port A request
        rfsh_req = 1; a_strobe = 1; a_sel = 1; a_hold = 1; addr_in = mk(3, 3, 3);
        cyc(1);
        rfsh_req = 0;
        cyc(12);
        a_hold = 0; a_strobe = 0;
        cyc(8);

        // R8: A arrives during a B access and is deferred
        tag = "R8"; addr_in = mk(1, 2, 2); b_req = 1;
        cyc(2);
        addr_in = mk(2, 8, 8); a_strobe = 1; a_sel = 1; a_hold = 1;
        cyc(2);
        b_req = 0;
        cyc(10);
        a_hold = 0; a_strobe = 0;
        cyc(8);

        // R10: pass-through address when latching is off
        tag = "R10"; latch_on = 0; addr_in = mk(0, 5, 5);
        a_strobe = 1; a_sel = 1; a_hold = 1;
        for (int k = 0; k < 6; k++) begin
            cyc(1);
            addr_in = mk(0, k, 15 - k);
        end
        a_hold = 0; a_strobe = 0;
        cyc(6);

        // R11: a fresh request right after release waits out the precharge
        tag = "R11"; latch_on = 1; addr_in = mk(1, 1, 1);
        a_strobe = 1; a_sel = 1; a_hold = 1;
        cyc(3);
        a_hold = 0; a_strobe = 0;
        cyc(1);
        a_strobe = 1; a_hold = 1; addr_in = mk(3, 7, 7);
        cyc(8);
        a_hold = 0; a_strobe = 0; a_sel = 0;
        cyc(8);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule